// File: doc/BRIEF.md
# Protected Nonvolatile Byte Write Controller

This block connects a CPU register bus to a byte-wide nonvolatile data array of 2^ADDR_W cells. Software reaches four bus registers, picked by a 2-bit select: address low byte, address high bits, data, and control. A read copies a cell into the data register and holds the CPU for a few cycles. A write must be armed first. Software sets an arm bit, and that bit clears itself after a short window. A write strobe given inside the window starts a timed programming operation. The operation erases the cell, programs it, or does both in turn. The array is a behavioural RAM. Programming time comes from a clock prescaler and a tick count for each phase, so a simulation can use short timings.

While an operation runs, the write strobe bit reads back as one. During that time the mode field, the address and read strobes are locked out. A level interrupt reports that the controller is ready. An external "flash busy" input blocks new writes and holds the interrupt low. If reset arrives while an operation runs, the operation still completes.

Top module: `nvm_write_ctrl`

## Requirements
- R1: The arm bit (control bit 2) reads one for exactly 4 cycles after software writes it as one, then clears by itself. A write strobe (control bit 1) starts an operation only if it reaches the bus on one of those 4 cycles. A strobe written together with the arm bit, or on the 5th cycle or later, is rejected. A started operation clears the arm bit.
- R2: A write strobe given while the arm bit is clear has no effect: no stall, no busy indication and no change to the cell.
- R3: The mode field (control bits 5:4) selects the operation. 00 erases and then programs, so the cell takes the data value. 01 erases only, so the cell becomes 0xFF. 10 programs only, so the cell becomes its old value ANDed with the data. 11 is reserved and starts nothing.
- R4: The busy time is PRESCALE*ERASE_TICKS cycles for mode 01, PRESCALE*PROG_TICKS cycles for mode 10, and the sum of the two for mode 00. With the defaults this is 20, 20 and 40 cycles. Control bit 1 reads one for the whole operation and is cleared by hardware at the end.
- R5: Writes to the mode field are ignored while an operation runs. Reset sets the mode field to 00 only if no operation is running.
- R6: While an operation runs, a read strobe (control bit 0) is ignored: the data register and the CPU stall both stay as they are. Writes to the address registers are also ignored.
- R7: A read strobe loads the addressed cell into the data register (select 2) and raises cpu_stall for exactly 4 cycles. Starting a write raises cpu_stall for exactly 2 cycles.
- R8: ready_irq is a registered level, one cycle behind its inputs. It equals interrupt enable (control bit 3) AND no operation running AND flash_busy low.
- R9: A write strobe has no effect while flash_busy is high.
- R10: Select 0 reads address bits 7:0. Select 1 reads address bits 9:8 in its bits 1:0, and bits 7:2 of select 1 always read zero.
- R11: If reset is asserted during an operation, the operation keeps its mode and finishes. The cell receives the result and control bit 1 stays set until the operation ends. Interrupt enable still resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 addr low, 1 addr high, 2 data, 3 control |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after bus_rd |
| bus_rvalid | output | 1 | Marks bus_rdata valid |
| flash_busy | input | 1 | External programming-busy input that blocks writes |
| cpu_stall | output | 1 | Holds the CPU after a read strobe or a write start |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
On every cycle, the assertions check the rules that govern starting an operation. An operation starts only when the arm bit was set and flash_busy was low, and the start consumes the arm. Each start raises the stall, and a reserved mode never runs. The mode stays frozen while busy, the busy run never exceeds the longest operation, and the interrupt never rises without its three conditions. Some behaviours can only be shown by the bench scenarios. These are the cell values each mode leaves behind, the exact busy lengths and stall lengths, and the closing edge of the 4-cycle arm window. The scenarios also cover reads and address writes that are ignored while busy, and an operation that finishes through a reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    PM_ERASE_WRITE = 2'b00,
    PM_ERASE       = 2'b01,
    PM_WRITE       = 2'b10,
    PM_RESERVED    = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    RS_ADDR_LO = 2'd0,
    RS_ADDR_HI = 2'd1,
    RS_DATA    = 2'd2,
    RS_CTRL    = 2'd3
  } regsel_e;

  localparam int CB_RD      = 0;
  localparam int CB_WR      = 1;
  localparam int CB_ARM     = 2;
  localparam int CB_IEN     = 3;
  localparam int CB_MODE_LO = 4;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int ARM_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(ARM_WIN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (consume_i)     cnt_q <= '0;
    else if (set_i)         cnt_q <= CNT_W'(ARM_WIN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign armed_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer import nvm_pkg::*; #(
  parameter int PRESCALE    = 4,
  parameter int ERASE_TICKS = 5,
  parameter int PROG_TICKS  = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  pmode_e mode_i,
  output logic   busy_o,
  output logic   done_o
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TICK_W = $clog2(ERASE_TICKS + PROG_TICKS + 1);

  logic [PRE_W-1:0]  pre_q;
  logic [TICK_W-1:0] left_q;
  logic [TICK_W-1:0] load_ticks;
  logic              tick;

  always_comb begin
    case (mode_i)
      PM_ERASE: load_ticks = TICK_W'(ERASE_TICKS);
      PM_WRITE: load_ticks = TICK_W'(PROG_TICKS);
      default:  load_ticks = TICK_W'(ERASE_TICKS + PROG_TICKS);
    endcase
  end

  assign tick   = (pre_q == PRE_W'(PRESCALE - 1));
  assign done_o = busy_o && tick && (left_q == TICK_W'(1));

  // A running operation is immune to reset; it always runs to its end.
  always_ff @(posedge clk) begin
    if (rst && !busy_o) begin
      busy_o <= 1'b0;
      pre_q  <= '0;
      left_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        pre_q  <= '0;
        left_q <= load_ticks;
      end
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick) begin
        left_q <= left_q - TICK_W'(1);
        if (left_q == TICK_W'(1)) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvm_stall.sv
module nvm_stall #(
  parameter int READ_STALL  = 4,
  parameter int WRITE_STALL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic read_i,
  input  logic write_i,
  output logic stall_o
);
  localparam int MAX_S = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
  localparam int CNT_W = $clog2(MAX_S + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (write_i)      cnt_q <= CNT_W'(WRITE_STALL);
    else if (read_i)       cnt_q <= CNT_W'(READ_STALL);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl import nvm_pkg::*; #(
  parameter int ADDR_W      = 10,
  parameter int BUS_W       = 8,
  parameter int ARM_WIN     = 4,
  parameter int PRESCALE    = 4,
  parameter int ERASE_TICKS = 5,
  parameter int PROG_TICKS  = 5,
  parameter int READ_STALL  = 4,
  parameter int WRITE_STALL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             bus_rvalid,
  input  logic             flash_busy,
  output logic             cpu_stall,
  output logic             ready_irq
);
  localparam int HI_W = ADDR_W - BUS_W;

  regsel_e           sel;
  logic              wr_lo, wr_hi, wr_dat, wr_ctrl;
  logic              busy, done, armed;
  pmode_e            mode_q, req_mode;
  logic              ien_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q, op_data_q, ram_q, cell_next;
  logic              rd_pend_q;
  logic              start, rd_start;
  logic [BUS_W-1:0]  hi_rd, ctrl_rd, rd_mux;

  assign sel      = regsel_e'(bus_sel);
  assign wr_lo    = bus_wr && (sel == RS_ADDR_LO);
  assign wr_hi    = bus_wr && (sel == RS_ADDR_HI);
  assign wr_dat   = bus_wr && (sel == RS_DATA);
  assign wr_ctrl  = bus_wr && (sel == RS_CTRL);
  assign req_mode = pmode_e'(bus_wdata[CB_MODE_LO+1:CB_MODE_LO]);

  assign start = !rst && wr_ctrl && bus_wdata[CB_WR] && armed && !busy &&
                 !flash_busy && (req_mode != PM_RESERVED);
  assign rd_start = !rst && wr_ctrl && bus_wdata[CB_RD] && !busy && !start;

  nvm_arm_window #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk       (clk),
    .rst       (rst),
    .set_i     (wr_ctrl && bus_wdata[CB_ARM]),
    .consume_i (start),
    .armed_o   (armed)
  );

  nvm_op_timer #(
    .PRESCALE    (PRESCALE),
    .ERASE_TICKS (ERASE_TICKS),
    .PROG_TICKS  (PROG_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .mode_i  (req_mode),
    .busy_o  (busy),
    .done_o  (done)
  );

  nvm_stall #(
    .READ_STALL  (READ_STALL),
    .WRITE_STALL (WRITE_STALL)
  ) u_stall (
    .clk     (clk),
    .rst     (rst),
    .read_i  (rd_start),
    .write_i (start),
    .stall_o (cpu_stall)
  );

  // The read issued at start keeps the old cell value for program-only mode.
  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_array (
    .clk     (clk),
    .rd_en   (start || rd_start),
    .rd_addr (addr_q),
    .rd_data (ram_q),
    .wr_en   (done),
    .wr_addr (addr_q),
    .wr_data (cell_next)
  );

  always_comb begin
    case (mode_q)
      PM_ERASE: cell_next = '1;
      PM_WRITE: cell_next = ram_q & op_data_q;
      default:  cell_next = op_data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= 1'b0;
      data_q    <= '0;
      rd_pend_q <= 1'b0;
      if (!busy) mode_q <= PM_ERASE_WRITE;
    end else begin
      rd_pend_q <= rd_start;
      if (wr_ctrl) ien_q <= bus_wdata[CB_IEN];
      if (wr_ctrl && !busy) mode_q <= req_mode;
      if (rd_pend_q)   data_q <= ram_q;
      else if (wr_dat) data_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (start) op_data_q <= data_q;
  end

  // Address has no reset value; it is frozen while an operation runs.
  always_ff @(posedge clk) begin
    if (!busy) begin
      if (wr_lo) addr_q[BUS_W-1:0]      <= bus_wdata;
      if (wr_hi) addr_q[ADDR_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
    end
  end

  always_comb begin
    hi_rd                     = '0;
    hi_rd[HI_W-1:0]           = addr_q[ADDR_W-1:BUS_W];
    ctrl_rd                   = '0;
    ctrl_rd[CB_MODE_LO+1:CB_MODE_LO] = mode_q;
    ctrl_rd[CB_IEN]           = ien_q;
    ctrl_rd[CB_ARM]           = armed;
    ctrl_rd[CB_WR]            = busy;
    case (sel)
      RS_ADDR_LO: rd_mux = addr_q[BUS_W-1:0];
      RS_ADDR_HI: rd_mux = hi_rd;
      RS_DATA:    rd_mux = data_q;
      default:    rd_mux = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      ready_irq  <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      ready_irq <= ien_q && !busy && !flash_busy;
    end
  end
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk import nvm_pkg::*; #(
  parameter int PRESCALE    = 4,
  parameter int ERASE_TICKS = 5,
  parameter int PROG_TICKS  = 5
) (
  input logic   clk,
  input logic   rst,
  input logic   busy,
  input logic   armed,
  input logic   flash_busy,
  input logic   ien_q,
  input logic   cpu_stall,
  input logic   ready_irq,
  input pmode_e mode_q
);
  localparam int MAX_BUSY = PRESCALE * (ERASE_TICKS + PROG_TICKS);
  localparam int RUN_W    = $clog2(MAX_BUSY + 2);

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!busy)                          busy_run <= '0;
    else if (busy_run <= RUN_W'(MAX_BUSY)) busy_run <= busy_run + RUN_W'(1);
  end

  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed)); // R1
  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !armed); // R1
  AST_MODE_NOT_RSVD: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mode_q != PM_RESERVED)); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(MAX_BUSY)); // R4
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q)); // R5
  AST_STALL_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> cpu_stall); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready_irq |-> $past(ien_q && !busy && !flash_busy)); // R8
  AST_START_NOT_FLASH: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(flash_busy)); // R9
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(
  .PRESCALE    (PRESCALE),
  .ERASE_TICKS (ERASE_TICKS),
  .PROG_TICKS  (PROG_TICKS)
) u_chk (.*);

// File: tb/tb_nvm_write_ctrl.sv
module tb_nvm_write_ctrl;
  localparam int PRESCALE    = 4;
  localparam int ERASE_TICKS = 5;
  localparam int PROG_TICKS  = 5;
  localparam int N_ERASE = PRESCALE * ERASE_TICKS;
  localparam int N_PROG  = PRESCALE * PROG_TICKS;
  localparam int N_BOTH  = N_ERASE + N_PROG;
  localparam logic [1:0] S_LO = 2'd0, S_HI = 2'd1, S_DAT = 2'd2, S_CTL = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid, flash_busy = 1'b0, cpu_stall, ready_irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] cur_mode = 2'd0;
  logic       cur_ien  = 1'b0;

  always #10 clk = ~clk;

  nvm_write_ctrl #(
    .PRESCALE(PRESCALE), .ERASE_TICKS(ERASE_TICKS), .PROG_TICKS(PROG_TICKS)
  ) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .flash_busy(flash_busy), .cpu_stall(cpu_stall), .ready_irq(ready_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cv(input logic [1:0] m, input logic ie,
                                    input logic arm, input logic wr, input logic rd);
    return {2'b00, m, ie, arm, wr, rd};
  endfunction

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver side of the scoreboard: push the expected value, issue the read.
  task automatic bus_read(input logic [1:0] s, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk("unexpected read data", 32'(bus_rdata), 32'hFFFF);
      else chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic pulse_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cell_read(input logic [7:0] exp, input string tag);
    bus_write(S_CTL, cv(cur_mode, cur_ien, 1'b0, 1'b0, 1'b1));
    for (int i = 0; i < 4; i++) begin
      chk("R7 read stall high", 32'(cpu_stall), 32'd1);
      @(negedge clk);
    end
    chk("R7 read stall released", 32'(cpu_stall), 32'd0);
    bus_read(S_DAT, exp, tag);
  endtask

  task automatic prog(input logic [1:0] m, input logic [7:0] d, input int gap,
                      input bit go, input int n, input string tag);
    int low;
    bus_write(S_DAT, d);
    bus_write(S_CTL, cv(m, cur_ien, 1'b1, 1'b0, 1'b0));
    repeat (gap) @(negedge clk);
    bus_write(S_CTL, cv(m, cur_ien, 1'b0, 1'b1, 1'b0));
    cur_mode = m;
    if (go) begin
      chk({tag, " R7 write stall"}, 32'(cpu_stall), 32'd1);
      @(negedge clk);
      chk({tag, " R7 write stall"}, 32'(cpu_stall), 32'd1);
      low = (ready_irq == 1'b0) ? 1 : 0;
      @(negedge clk);
      chk({tag, " R7 write stall end"}, 32'(cpu_stall), 32'd0);
      while (ready_irq == 1'b0 && low < 1000) begin
        low++;
        @(negedge clk);
      end
      chk({tag, " R4 busy length"}, 32'(low), 32'(n));
    end else begin
      chk({tag, " no stall"}, 32'(cpu_stall), 32'd0);
      @(negedge clk);
      chk({tag, " irq unaffected"}, 32'(ready_irq), 32'(cur_ien && !flash_busy));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R8 irq after reset", 32'(ready_irq), 32'd0);
    chk("R7 stall after reset", 32'(cpu_stall), 32'd0);
    bus_read(S_CTL, 8'h00, "R5 control after reset");

    // R8: interrupt level follows enable one cycle later
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    cur_ien = 1'b1;
    chk("R8 irq lag", 32'(ready_irq), 32'd0);
    @(negedge clk);
    chk("R8 irq set", 32'(ready_irq), 32'd1);

    // R10: address registers
    bus_write(S_HI, 8'hFF);
    bus_write(S_LO, 8'h21);
    bus_read(S_HI, 8'h03, "R10 addr high zero fill");
    bus_read(S_LO, 8'h21, "R10 addr low");

    // R3 / R4: the three modes
    prog(2'd1, 8'h00, 0, 1'b1, N_ERASE, "R3 erase");
    cell_read(8'hFF, "R3 erase result");
    prog(2'd2, 8'hA5, 0, 1'b1, N_PROG, "R3 program");
    cell_read(8'hA5, "R3 program result");
    prog(2'd2, 8'h3C, 0, 1'b1, N_PROG, "R3 program AND");
    cell_read(8'h24, "R3 program AND result");
    prog(2'd0, 8'h3C, 0, 1'b1, N_BOTH, "R3 erase+program");
    cell_read(8'h3C, "R3 erase+program result");
    prog(2'd3, 8'h55, 0, 1'b0, 0, "R3 reserved mode");
    cell_read(8'h3C, "R3 reserved leaves cell");

    // R2: strobe without arm; R1: arm and strobe together
    bus_write(S_DAT, 8'h66);
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    cur_mode = 2'd0;
    chk("R2 no stall without arm", 32'(cpu_stall), 32'd0);
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b0, 1'b0), "R2 not busy");
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
    chk("R1 same-write strobe rejected", 32'(cpu_stall), 32'd0);
    repeat (5) @(negedge clk);
    cell_read(8'h3C, "R2 cell untouched");

    // R1: arm window readback and edges
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b1, 1'b0, 1'b0), "R1 arm visible");
    repeat (3) @(negedge clk);
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b0, 1'b0), "R1 arm self-cleared");
    prog(2'd0, 8'h77, 3, 1'b1, N_BOTH, "R1 strobe on 4th cycle");
    cell_read(8'h77, "R1 late accepted result");
    prog(2'd0, 8'h99, 4, 1'b0, 0, "R1 strobe on 5th cycle");
    cell_read(8'h77, "R1 expired window cell");

    // R5 / R6: lockouts while busy
    bus_write(S_DAT, 8'h11);
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
    bus_write(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    bus_write(S_LO, 8'h00);
    bus_write(S_CTL, cv(2'd1, 1'b1, 1'b0, 1'b0, 1'b1));
    chk("R6 read strobe no stall while busy", 32'(cpu_stall), 32'd0);
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b1, 1'b0), "R5 mode locked, R4 busy bit");
    bus_read(S_LO, 8'h21, "R6 address locked");
    bus_read(S_DAT, 8'h11, "R6 read ignored");
    for (int i = 0; i < 200 && ready_irq == 1'b0; i++) @(negedge clk);
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b0, 1'b0, 1'b0), "R4 busy bit cleared");
    cell_read(8'h11, "R6 op result");

    // R9: flash busy blocks start and holds irq low
    flash_busy = 1'b1;
    @(negedge clk);
    chk("R8 irq low on flash busy", 32'(ready_irq), 32'd0);
    prog(2'd0, 8'hEE, 0, 1'b0, 0, "R9 flash busy");
    bus_read(S_CTL, cv(2'd0, 1'b1, 1'b1, 1'b0, 1'b0), "R9 not started");
    flash_busy = 1'b0;
    repeat (6) @(negedge clk);
    cell_read(8'h11, "R9 cell untouched");

    // R5: reset restores mode when idle
    bus_write(S_CTL, cv(2'd2, 1'b1, 1'b0, 1'b0, 1'b0));
    bus_read(S_CTL, 8'h28, "R5 mode written");
    pulse_reset();
    cur_ien = 1'b0; cur_mode = 2'd0;
    bus_read(S_CTL, 8'h00, "R5 mode reset when idle");

    // R11: reset during an operation lets it finish
    bus_write(S_DAT, 8'h5A);
    bus_write(S_CTL, cv(2'd2, 1'b0, 1'b1, 1'b0, 1'b0));
    bus_write(S_CTL, cv(2'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    cur_mode = 2'd2;
    repeat (3) @(negedge clk);
    pulse_reset();
    bus_read(S_CTL, 8'h22, "R11 still busy after reset");
    repeat (30) @(negedge clk);
    bus_read(S_CTL, 8'h20, "R11 finished");
    cell_read(8'h10, "R11 result written");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule